// File: doc/BRIEF.md
# Partition freeze state filter

This block keeps a freeze state for every isolation partition and filters traffic that has already been tagged with a partition number. Each partition has two flags. One gates accesses that the host sends towards devices (MMIO). The other gates device-initiated memory traffic (DMA) and message-signalled interrupts. A freeze sets both flags in the same cycle. It can come from a control strobe or from a fault report. Software-style strobes can later clear either flag on its own, so a partition can be thawed one direction at a time.

Every request, completion and interrupt passes through one register stage. Writes that belong to a frozen direction are dropped. Read completions that belong to a frozen direction keep their valid strobe, but their data is replaced with all ones. Interrupts from a partition whose DMA flag is set are discarded. The decision for a transaction uses the table as it stands in the cycle the transaction is presented. A freeze or clear issued in cycle t therefore first affects transactions presented in cycle t+1.

Top module: `pe_freeze_filter`

## Requirements
- R1: After reset every flag of every partition is clear, all output valids are low, and all traffic passes unmodified.
- R2: A freeze strobe or a fault report for partition p sets both the MMIO and DMA flags of p. Both flags apply to transactions presented from the next cycle on. Two freezes for different partitions in one cycle both take effect.
- R3: The MMIO clear strobe for partition p clears only the MMIO flag of p. The DMA flag of p and all flags of other partitions are unchanged.
- R4: The DMA clear strobe for partition p clears only the DMA flag of p. The MMIO flag of p and all flags of other partitions are unchanged.
- R5: If a freeze and a clear target the same partition in the same cycle, both flags of that partition end up set.
- R6: An MMIO request is forwarded one cycle later with its write flag (1 = write), address and data unchanged. The only exception is a write from a partition whose MMIO flag is set: that write produces no forwarded valid.
- R7: Every MMIO read completion produces a response valid one cycle later. Its data is all ones if the partition's MMIO flag is set, and is passed through unchanged otherwise.
- R8: A DMA write from a partition whose DMA flag is set is not forwarded. Other DMA requests are forwarded one cycle later unchanged. DMA read completions keep their valid, and their data is all ones while the DMA flag is set.
- R9: An interrupt from a partition whose DMA flag is set is discarded. Any other interrupt is forwarded one cycle later with its vector unchanged.
- R10: Read requests are forwarded in both directions regardless of freeze state, so that every read gets a completion.
- R11: The MMIO flag never affects DMA or interrupt traffic, and the DMA flag never affects MMIO traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frz_vld | input | 1 | Freeze strobe |
| frz_id | input | PW | Partition to freeze |
| flt_vld | input | 1 | Fault report strobe (freezes) |
| flt_id | input | PW | Partition reported as faulty |
| clr_mmio_vld | input | 1 | Clear MMIO flag strobe |
| clr_mmio_id | input | PW | Partition whose MMIO flag is cleared |
| clr_dma_vld | input | 1 | Clear DMA flag strobe |
| clr_dma_id | input | PW | Partition whose DMA flag is cleared |
| mmio_req_vld | input | 1 | Host-to-device request valid |
| mmio_req_we | input | 1 | 1 = write, 0 = read |
| mmio_req_part | input | PW | Partition of the request |
| mmio_req_addr | input | ADDR_W | Request address |
| mmio_req_wdata | input | DATA_W | Write data |
| mmio_fwd_vld | output | 1 | Forwarded request valid |
| mmio_fwd_we | output | 1 | Forwarded write flag |
| mmio_fwd_addr | output | ADDR_W | Forwarded address |
| mmio_fwd_wdata | output | DATA_W | Forwarded write data |
| mmio_cpl_vld | input | 1 | Read completion from device |
| mmio_cpl_part | input | PW | Partition of the completion |
| mmio_cpl_data | input | DATA_W | Completion data |
| mmio_rsp_vld | output | 1 | Response valid to host |
| mmio_rsp_data | output | DATA_W | Response data (all ones when frozen) |
| dma_req_vld | input | 1 | Device-to-memory request valid |
| dma_req_we | input | 1 | 1 = write, 0 = read |
| dma_req_part | input | PW | Partition of the request |
| dma_req_addr | input | ADDR_W | Request address |
| dma_req_wdata | input | DATA_W | Write data |
| dma_fwd_vld | output | 1 | Forwarded DMA request valid |
| dma_fwd_we | output | 1 | Forwarded write flag |
| dma_fwd_addr | output | ADDR_W | Forwarded address |
| dma_fwd_wdata | output | DATA_W | Forwarded write data |
| dma_cpl_vld | input | 1 | Memory read completion valid |
| dma_cpl_part | input | PW | Partition of the completion |
| dma_cpl_data | input | DATA_W | Completion data |
| dma_rsp_vld | output | 1 | Completion valid to device |
| dma_rsp_data | output | DATA_W | Completion data (all ones when frozen) |
| msi_vld | input | 1 | Interrupt message valid |
| msi_part | input | PW | Partition of the interrupt |
| msi_vec | input | VEC_W | Interrupt vector |
| msi_fwd_vld | output | 1 | Forwarded interrupt valid |
| msi_fwd_vec | output | VEC_W | Forwarded interrupt vector |

## Verification
The assertions assume that every partition number on the inputs is below NUM_PART. They also assume that transaction strobes are single-cycle pulses with no backpressure, because each input is sampled once and registered. The bench drives 8-bit partition numbers into the default 256-entry table, so every value is in range, and it changes inputs only between edges. Random partition numbers come mostly from a small pool. This makes freezes, clears and traffic land on the same partition often, including freeze-versus-clear collisions and two freeze sources hitting in one cycle.

// File: rtl/pe_freeze_filter.sv
module pe_freeze_filter #(
  parameter int NUM_PART = 256,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 11,
  localparam int PW      = $clog2(NUM_PART)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_vld,
  input  logic [PW-1:0]     frz_id,
  input  logic              flt_vld,
  input  logic [PW-1:0]     flt_id,
  input  logic              clr_mmio_vld,
  input  logic [PW-1:0]     clr_mmio_id,
  input  logic              clr_dma_vld,
  input  logic [PW-1:0]     clr_dma_id,
  input  logic              mmio_req_vld,
  input  logic              mmio_req_we,
  input  logic [PW-1:0]     mmio_req_part,
  input  logic [ADDR_W-1:0] mmio_req_addr,
  input  logic [DATA_W-1:0] mmio_req_wdata,
  output logic              mmio_fwd_vld,
  output logic              mmio_fwd_we,
  output logic [ADDR_W-1:0] mmio_fwd_addr,
  output logic [DATA_W-1:0] mmio_fwd_wdata,
  input  logic              mmio_cpl_vld,
  input  logic [PW-1:0]     mmio_cpl_part,
  input  logic [DATA_W-1:0] mmio_cpl_data,
  output logic              mmio_rsp_vld,
  output logic [DATA_W-1:0] mmio_rsp_data,
  input  logic              dma_req_vld,
  input  logic              dma_req_we,
  input  logic [PW-1:0]     dma_req_part,
  input  logic [ADDR_W-1:0] dma_req_addr,
  input  logic [DATA_W-1:0] dma_req_wdata,
  output logic              dma_fwd_vld,
  output logic              dma_fwd_we,
  output logic [ADDR_W-1:0] dma_fwd_addr,
  output logic [DATA_W-1:0] dma_fwd_wdata,
  input  logic              dma_cpl_vld,
  input  logic [PW-1:0]     dma_cpl_part,
  input  logic [DATA_W-1:0] dma_cpl_data,
  output logic              dma_rsp_vld,
  output logic [DATA_W-1:0] dma_rsp_data,
  input  logic              msi_vld,
  input  logic [PW-1:0]     msi_part,
  input  logic [VEC_W-1:0]  msi_vec,
  output logic              msi_fwd_vld,
  output logic [VEC_W-1:0]  msi_fwd_vec
);

  logic [NUM_PART-1:0] mmio_frz, dma_frz;

  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    wire hit_frz = (frz_vld && frz_id == PW'(i)) || (flt_vld && flt_id == PW'(i));
    wire hit_cm  = clr_mmio_vld && clr_mmio_id == PW'(i);
    wire hit_cd  = clr_dma_vld && clr_dma_id == PW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mmio_frz[i] <= 1'b0;
        dma_frz[i]  <= 1'b0;
      end else if (hit_frz) begin
        mmio_frz[i] <= 1'b1;
        dma_frz[i]  <= 1'b1;
      end else begin
        if (hit_cm) mmio_frz[i] <= 1'b0;
        if (hit_cd) dma_frz[i]  <= 1'b0;
      end
    end
  end

  wire m_req_frz = mmio_frz[mmio_req_part];
  wire m_cpl_frz = mmio_frz[mmio_cpl_part];
  wire d_req_frz = dma_frz[dma_req_part];
  wire d_cpl_frz = dma_frz[dma_cpl_part];
  wire i_frz     = dma_frz[msi_part];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mmio_fwd_vld   <= 1'b0;
      mmio_fwd_we    <= 1'b0;
      mmio_fwd_addr  <= '0;
      mmio_fwd_wdata <= '0;
      mmio_rsp_vld   <= 1'b0;
      mmio_rsp_data  <= '0;
      dma_fwd_vld    <= 1'b0;
      dma_fwd_we     <= 1'b0;
      dma_fwd_addr   <= '0;
      dma_fwd_wdata  <= '0;
      dma_rsp_vld    <= 1'b0;
      dma_rsp_data   <= '0;
      msi_fwd_vld    <= 1'b0;
      msi_fwd_vec    <= '0;
    end else begin
      mmio_fwd_vld   <= mmio_req_vld && !(mmio_req_we && m_req_frz);
      mmio_fwd_we    <= mmio_req_we;
      mmio_fwd_addr  <= mmio_req_addr;
      mmio_fwd_wdata <= mmio_req_wdata;
      mmio_rsp_vld   <= mmio_cpl_vld;
      mmio_rsp_data  <= m_cpl_frz ? '1 : mmio_cpl_data;
      dma_fwd_vld    <= dma_req_vld && !(dma_req_we && d_req_frz);
      dma_fwd_we     <= dma_req_we;
      dma_fwd_addr   <= dma_req_addr;
      dma_fwd_wdata  <= dma_req_wdata;
      dma_rsp_vld    <= dma_cpl_vld;
      dma_rsp_data   <= d_cpl_frz ? '1 : dma_cpl_data;
      msi_fwd_vld    <= msi_vld && !i_frz;
      msi_fwd_vec    <= msi_vec;
    end
  end

  AST_FRZ_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    frz_vld |=> (mmio_frz[$past(frz_id)] && dma_frz[$past(frz_id)])); // R2
  AST_FLT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && clr_mmio_vld && clr_dma_vld && clr_mmio_id == flt_id && clr_dma_id == flt_id)
      |=> (mmio_frz[$past(flt_id)] && dma_frz[$past(flt_id)])); // R5
  AST_CLR_MMIO_KEEPS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mmio_vld && !clr_dma_vld && !frz_vld && !flt_vld)
      |=> (!mmio_frz[$past(clr_mmio_id)] && dma_frz[$past(clr_mmio_id)] == $past(dma_frz[clr_mmio_id]))); // R3
  AST_CLR_DMA_KEEPS_MMIO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dma_vld && !clr_mmio_vld && !frz_vld && !flt_vld)
      |=> (!dma_frz[$past(clr_dma_id)] && mmio_frz[$past(clr_dma_id)] == $past(mmio_frz[clr_dma_id]))); // R4
  AST_MMIO_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req_vld && mmio_req_we && mmio_frz[mmio_req_part]) |=> !mmio_fwd_vld); // R6
  AST_MMIO_RSP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_cpl_vld && mmio_frz[mmio_cpl_part]) |=> (mmio_rsp_vld && mmio_rsp_data == '1)); // R7
  AST_DMA_RSP_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cpl_vld |=> dma_rsp_vld); // R8
  AST_MSI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_vld && dma_frz[msi_part]) |=> !msi_fwd_vld); // R9
  AST_READ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mmio_req_vld && !mmio_req_we) || (dma_req_vld && !dma_req_we))
      |=> (mmio_fwd_vld || !$past(mmio_req_vld && !mmio_req_we))
       && (dma_fwd_vld || !$past(dma_req_vld && !dma_req_we))); // R10

endmodule

// File: tb/pe_freeze_filter_test.sv
module pe_freeze_filter_test;
  localparam int PW = 8;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic frz_vld, flt_vld, clr_mmio_vld, clr_dma_vld;
  logic [PW-1:0] frz_id, flt_id, clr_mmio_id, clr_dma_id;
  logic mmio_req_vld, mmio_req_we; logic [PW-1:0] mmio_req_part;
  logic [31:0] mmio_req_addr, mmio_req_wdata;
  logic mmio_fwd_vld, mmio_fwd_we; logic [31:0] mmio_fwd_addr, mmio_fwd_wdata;
  logic mmio_cpl_vld; logic [PW-1:0] mmio_cpl_part; logic [31:0] mmio_cpl_data;
  logic mmio_rsp_vld; logic [31:0] mmio_rsp_data;
  logic dma_req_vld, dma_req_we; logic [PW-1:0] dma_req_part;
  logic [31:0] dma_req_addr, dma_req_wdata;
  logic dma_fwd_vld, dma_fwd_we; logic [31:0] dma_fwd_addr, dma_fwd_wdata;
  logic dma_cpl_vld; logic [PW-1:0] dma_cpl_part; logic [31:0] dma_cpl_data;
  logic dma_rsp_vld; logic [31:0] dma_rsp_data;
  logic msi_vld; logic [PW-1:0] msi_part; logic [10:0] msi_vec;
  logic msi_fwd_vld; logic [10:0] msi_fwd_vec;

  pe_freeze_filter uut (.*);

  bit mf [256];
  bit df [256];
  logic e_mfv, e_mfwe, e_mrv, e_dfv, e_dfwe, e_drv, e_iv;
  logic [31:0] e_mfa, e_mfd, e_mrd, e_dfa, e_dfd, e_drd;
  logic [10:0] e_iv_vec;
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    frz_vld = 0; flt_vld = 0; clr_mmio_vld = 0; clr_dma_vld = 0;
    frz_id = 0; flt_id = 0; clr_mmio_id = 0; clr_dma_id = 0;
    mmio_req_vld = 0; mmio_req_we = 0; mmio_req_part = 0; mmio_req_addr = 0; mmio_req_wdata = 0;
    mmio_cpl_vld = 0; mmio_cpl_part = 0; mmio_cpl_data = 0;
    dma_req_vld = 0; dma_req_we = 0; dma_req_part = 0; dma_req_addr = 0; dma_req_wdata = 0;
    dma_cpl_vld = 0; dma_cpl_part = 0; dma_cpl_data = 0;
    msi_vld = 0; msi_part = 0; msi_vec = 0;
  endtask

  // compute expected outputs from the model, then advance the model
  task automatic apply();
    e_mfv = mmio_req_vld && !(mmio_req_we && mf[mmio_req_part]);
    e_mfwe = mmio_req_we; e_mfa = mmio_req_addr; e_mfd = mmio_req_wdata;
    e_mrv = mmio_cpl_vld; e_mrd = mf[mmio_cpl_part] ? 32'hFFFF_FFFF : mmio_cpl_data;
    e_dfv = dma_req_vld && !(dma_req_we && df[dma_req_part]);
    e_dfwe = dma_req_we; e_dfa = dma_req_addr; e_dfd = dma_req_wdata;
    e_drv = dma_cpl_vld; e_drd = df[dma_cpl_part] ? 32'hFFFF_FFFF : dma_cpl_data;
    e_iv = msi_vld && !df[msi_part]; e_iv_vec = msi_vec;
    if (clr_mmio_vld) mf[clr_mmio_id] = 0;
    if (clr_dma_vld) df[clr_dma_id] = 0;
    if (frz_vld) begin mf[frz_id] = 1; df[frz_id] = 1; end
    if (flt_vld) begin mf[flt_id] = 1; df[flt_id] = 1; end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R6 mmio fwd vld", mmio_fwd_vld, e_mfv);
    if (e_mfv) begin
      chk("R6 mmio fwd we", mmio_fwd_we, e_mfwe);
      chk("R6 mmio fwd addr", mmio_fwd_addr, e_mfa);
      chk("R6 mmio fwd data", mmio_fwd_wdata, e_mfd);
    end
    chk("R7 mmio rsp vld", mmio_rsp_vld, e_mrv);
    if (e_mrv) chk("R7 mmio rsp data", mmio_rsp_data, e_mrd);
    chk("R8 dma fwd vld", dma_fwd_vld, e_dfv);
    if (e_dfv) begin
      chk("R8 dma fwd we", dma_fwd_we, e_dfwe);
      chk("R8 dma fwd addr", dma_fwd_addr, e_dfa);
      chk("R8 dma fwd data", dma_fwd_wdata, e_dfd);
    end
    chk("R8 dma rsp vld", dma_rsp_vld, e_drv);
    if (e_drv) chk("R8 dma rsp data", dma_rsp_data, e_drd);
    chk("R9 msi fwd vld", msi_fwd_vld, e_iv);
    if (e_iv) chk("R9 msi fwd vec", msi_fwd_vec, e_iv_vec);
  endtask

  function automatic logic [7:0] pick();
    int r = $urandom_range(0, 9);
    return (r < 9) ? 8'(r) : 8'hFF;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    e_mfv = 0; e_mfwe = 0; e_mrv = 0; e_dfv = 0; e_dfwe = 0; e_drv = 0; e_iv = 0;
    e_mfa = 0; e_mfd = 0; e_mrd = 0; e_dfa = 0; e_dfd = 0; e_drd = 0; e_iv_vec = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset mmio", {mmio_fwd_vld, mmio_rsp_vld}, 0);
    chk("R1 reset dma", {dma_fwd_vld, dma_rsp_vld, msi_fwd_vld}, 0);
    rst_n = 1;

    // R1: every partition starts thawed: writes and interrupts pass
    for (int p = 0; p < 256; p++) begin
      idle();
      mmio_req_vld = 1; mmio_req_we = 1; mmio_req_part = 8'(p); mmio_req_addr = p; mmio_req_wdata = ~p;
      msi_vld = 1; msi_part = 8'(p); msi_vec = 11'(p);
      apply(); tick();
      chk("R1 thawed write passes", mmio_fwd_vld, 1);
    end

    // R2: fault report freezes both flags of partition 3
    idle(); flt_vld = 1; flt_id = 3; apply(); tick();
    idle(); mmio_req_vld = 1; mmio_req_we = 1; mmio_req_part = 3;
    dma_req_vld = 1; dma_req_we = 1; dma_req_part = 3;
    msi_vld = 1; msi_part = 3; msi_vec = 5; apply(); tick();
    chk("R2 mmio write dropped", mmio_fwd_vld, 0);
    chk("R2 dma write dropped", dma_fwd_vld, 0);
    chk("R2 msi dropped", msi_fwd_vld, 0);

    // R10: reads still forwarded; R7 completion all ones
    idle(); mmio_req_vld = 1; mmio_req_part = 3; dma_req_vld = 1; dma_req_part = 3;
    mmio_cpl_vld = 1; mmio_cpl_part = 3; mmio_cpl_data = 32'h1234_5678; apply(); tick();
    chk("R10 mmio read fwd", mmio_fwd_vld, 1);
    chk("R10 dma read fwd", dma_fwd_vld, 1);
    chk("R7 frozen rsp ones", mmio_rsp_data, 32'hFFFF_FFFF);

    // R3 and R11: clear MMIO only; MMIO passes, interrupt still blocked
    idle(); clr_mmio_vld = 1; clr_mmio_id = 3; apply(); tick();
    idle(); mmio_req_vld = 1; mmio_req_we = 1; mmio_req_part = 3;
    msi_vld = 1; msi_part = 3; apply(); tick();
    chk("R3 mmio thawed", mmio_fwd_vld, 1);
    chk("R11 dma flag still gates msi", msi_fwd_vld, 0);

    // R4: clear DMA only
    idle(); clr_dma_vld = 1; clr_dma_id = 3; frz_vld = 1; frz_id = 4; apply(); tick();
    idle(); msi_vld = 1; msi_part = 3; dma_cpl_vld = 1; dma_cpl_part = 4; dma_cpl_data = 7;
    apply(); tick();
    chk("R4 dma thawed", msi_fwd_vld, 1);
    chk("R8 frozen dma cpl ones", dma_rsp_data, 32'hFFFF_FFFF);

    // R5: freeze wins over clears in the same cycle
    idle(); frz_vld = 1; frz_id = 6; clr_mmio_vld = 1; clr_mmio_id = 6;
    clr_dma_vld = 1; clr_dma_id = 6; apply(); tick();
    idle(); mmio_req_vld = 1; mmio_req_we = 1; mmio_req_part = 6;
    msi_vld = 1; msi_part = 6; apply(); tick();
    chk("R5 mmio still frozen", mmio_fwd_vld, 0);
    chk("R5 dma still frozen", msi_fwd_vld, 0);

    // R2: two freeze sources on different partitions in one cycle
    idle(); frz_vld = 1; frz_id = 7; flt_vld = 1; flt_id = 8'hFF; apply(); tick();
    idle(); mmio_req_vld = 1; mmio_req_we = 1; mmio_req_part = 7;
    dma_req_vld = 1; dma_req_we = 1; dma_req_part = 8'hFF; apply(); tick();
    chk("R2 ctl freeze", mmio_fwd_vld, 0);
    chk("R2 fault freeze", dma_fwd_vld, 0);

    // random traffic against the model (all requirements)
    for (int n = 0; n < 20000; n++) begin
      idle();
      frz_vld = ($urandom_range(0, 15) == 0); frz_id = pick();
      flt_vld = ($urandom_range(0, 19) == 0); flt_id = pick();
      clr_mmio_vld = ($urandom_range(0, 5) == 0); clr_mmio_id = pick();
      clr_dma_vld = ($urandom_range(0, 5) == 0); clr_dma_id = pick();
      mmio_req_vld = $urandom_range(0, 1); mmio_req_we = $urandom_range(0, 1);
      mmio_req_part = pick(); mmio_req_addr = $urandom; mmio_req_wdata = $urandom;
      mmio_cpl_vld = $urandom_range(0, 1); mmio_cpl_part = pick(); mmio_cpl_data = $urandom;
      dma_req_vld = $urandom_range(0, 1); dma_req_we = $urandom_range(0, 1);
      dma_req_part = pick(); dma_req_addr = $urandom; dma_req_wdata = $urandom;
      dma_cpl_vld = $urandom_range(0, 1); dma_cpl_part = pick(); dma_cpl_data = $urandom;
      msi_vld = $urandom_range(0, 1); msi_part = pick(); msi_vec = 11'($urandom);
      apply(); tick();
    end
    idle(); apply(); tick();
    summary();
  end
endmodule